// File: doc/BRIEF.md
# DDR Burst Column Address Generator

This block produces the column addresses of one read or write burst on a double-data-rate memory device. A start strobe captures a starting column, an auto-precharge request bit and a four-bit mode value holding the burst-length code and the burst-order bit. From the next clock on, the block presents two column addresses per clock: one for the beat on the rising data edge and one for the beat on the falling edge. It continues until the burst is complete or a terminate input cuts it short.

The burst never leaves the column block aligned to its own length. Only the low one, two or three column bits move, either by counting with wraparound (linear order) or by XOR with the beat number (interleaved order). A reserved length code produces an error pulse and no beats. A start strobe on the clock that shows the final address pair of a burst opens the next burst with no idle clock between them. This lets a memory controller stream back-to-back column commands.

Top module: `ddr_burst_colgen`

## Requirements
- R1: The length code in mode bits [2:0] selects the burst length: 3'b001 gives 2 beats, 3'b010 gives 4 and 3'b011 gives 8. The beats appear two per clock (1, 2 or 4 clocks). The first pair is valid on the clock after the one where start_i is sampled high.
- R2: With mode bit [3] at 0 (linear order), beat k carries the low log2(L) column bits equal to (start + k) mod L.
- R3: With mode bit [3] at 1 (interleaved order), beat k carries the low log2(L) column bits equal to start XOR k.
- R4: Column bits at and above position log2(L) equal those of the start column for the whole burst. Beat 2p appears on col_rise_o and beat 2p+1 on col_fall_o in the p-th valid clock.
- R5: The auto-precharge request present at start_i is shown on ap_o while the burst's pairs are valid.
- R6: done_o pulses for one clock, in the same clock as the final pair of a burst that runs to its end.
- R7: term_i sampled high while a non-final pair is shown removes beat_valid_o on the next clock, pulses done_o then, and drops the remaining beats. term_i while idle, or while the final pair is shown, has no effect on beat_valid_o or done_o.
- R8: A length code other than 001, 010 or 011 at start gives, on the next clock, err_o and done_o high for one clock with beat_valid_o low.
- R9: start_i is accepted on any clock and takes priority over term_i. A start on the clock that shows the final pair yields the new burst's first pair on the next clock, with no gap. A start during an unfinished burst abandons it without a done pulse.
- R10: While rst_n is low, beat_valid_o, done_o, err_o and ap_o are 0 and both column outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins a burst with the values on the inputs below |
| start_col_i | input | 10 | Starting column address |
| ap_req_i | input | 1 | Auto-precharge request carried with the burst |
| mode_i | input | 4 | [2:0] length code, [3] order (0 linear, 1 interleaved) |
| term_i | input | 1 | Stops the running burst |
| beat_valid_o | output | 1 | Column outputs hold a valid pair |
| col_rise_o | output | 10 | Column for the rising-edge beat |
| col_fall_o | output | 10 | Column for the falling-edge beat |
| ap_o | output | 1 | Auto-precharge request of the current burst |
| done_o | output | 1 | One-clock pulse: burst finished, stopped or rejected |
| err_o | output | 1 | One-clock pulse: reserved length code at start |

## Verification
The hardest conditions to reach are the edges between bursts. A terminate must fall on exactly one chosen non-final pair. A new start must coincide with the final pair, or cut into a burst still running. Neither arises from isolated bursts with idle time between them. The stimulus therefore gives each random burst a chosen stop point and a chosen hand-off pair, at which the next burst's start is raised while the current pair is still on the outputs. Directed cases add terminate while idle, terminate on the final pair, and reserved codes arriving back-to-back after a valid burst.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    // Width of the burst-length code field in the mode value
    localparam int LEN_CODE_W = 3;
    // Largest burst is 2**MAX_LEN_LOG beats
    localparam int MAX_LEN_LOG = 3;
    // Beats per clock (one per data edge)
    localparam int LANES = 2;
    // Width of a log2(length) value
    localparam int LOG_W = $clog2(MAX_LEN_LOG + 1);
    // Width of a pair index inside a burst
    localparam int PAIR_W = MAX_LEN_LOG - $clog2(LANES);

    // Order selection held with a burst
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } burst_order_e;

endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
    import colgen_pkg::*;
(
    input  logic [LEN_CODE_W-1:0] len_code_i,
    output logic [LOG_W-1:0]      len_log_o,
    output logic [PAIR_W-1:0]     last_pair_o,
    output logic                  reserved_o
);

    always_comb begin
        len_log_o   = '0;
        reserved_o  = 1'b0;
        unique case (len_code_i)
            3'b001:  len_log_o = LOG_W'(1);
            3'b010:  len_log_o = LOG_W'(2);
            3'b011:  len_log_o = LOG_W'(3);
            default: reserved_o = 1'b1;
        endcase
    end

    // Number of pairs minus one: 2**(log-1) - 1
    always_comb begin
        if (reserved_o) begin
            last_pair_o = '0;
        end else begin
            last_pair_o = PAIR_W'((1 << (len_log_o - 1)) - 1);
        end
    end

endmodule

// File: rtl/colgen_order.sv
module colgen_order
    import colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0]            base_i,
    input  logic [PAIR_W-1:0]           pair_i,
    input  logic [LOG_W-1:0]            len_log_i,
    input  burst_order_e                order_i,
    output logic [LANES-1:0][COL_W-1:0] lane_col_o
);

    localparam int LANE_W = $clog2(LANES);

    logic [COL_W-1:0] wrap_mask;

    always_comb begin
        wrap_mask = COL_W'((1 << len_log_i) - 1);
    end

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [COL_W-1:0] beat_num;
        logic [COL_W-1:0] moved;

        always_comb begin
            beat_num = COL_W'({pair_i, LANE_W'(ln)});
            if (order_i == ORD_XOR) begin
                moved = base_i ^ beat_num;
            end else begin
                moved = base_i + beat_num;
            end
            lane_col_o[ln] = (base_i & ~wrap_mask) | (moved & wrap_mask);
        end
    end

endmodule

// File: rtl/colgen_ctrl.sv
module colgen_ctrl
    import colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [COL_W-1:0]            start_col_i,
    input  logic                        ap_req_i,
    input  logic                        order_bit_i,
    input  logic                        term_i,
    input  logic [LOG_W-1:0]            dec_log_i,
    input  logic [PAIR_W-1:0]           dec_last_i,
    input  logic                        dec_reserved_i,
    input  logic [LANES-1:0][COL_W-1:0] lane_col_i,
    output logic [COL_W-1:0]            calc_base_o,
    output logic [PAIR_W-1:0]           calc_pair_o,
    output logic [LOG_W-1:0]            calc_log_o,
    output burst_order_e                calc_order_o,
    output logic                        valid_o,
    output logic [COL_W-1:0]            col_rise_o,
    output logic [COL_W-1:0]            col_fall_o,
    output logic                        ap_o,
    output logic                        done_o,
    output logic                        err_o
);

    typedef struct packed {
        logic                        valid;
        logic                        done;
        logic                        err;
        logic                        ap;
        burst_order_e                order;
        logic [LOG_W-1:0]            len_log;
        logic [PAIR_W-1:0]           last;
        logic [PAIR_W-1:0]           pair;
        logic [COL_W-1:0]            base;
        logic [LANES-1:0][COL_W-1:0] cols;
    } gen_state_t;

    gen_state_t st_d, st_q;
    logic       more_q;

    always_comb begin
        more_q = st_q.valid && (st_q.pair != st_q.last);
    end

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.err     = 1'b0;
        calc_base_o  = st_q.base;
        calc_pair_o  = st_q.pair + PAIR_W'(1);
        calc_log_o   = st_q.len_log;
        calc_order_o = st_q.order;

        if (start_i) begin
            calc_base_o  = start_col_i;
            calc_pair_o  = '0;
            calc_log_o   = dec_log_i;
            calc_order_o = burst_order_e'(order_bit_i);
            if (dec_reserved_i) begin
                st_d.valid = 1'b0;
                st_d.err   = 1'b1;
                st_d.done  = 1'b1;
                st_d.ap    = 1'b0;
                st_d.cols  = '0;
            end else begin
                st_d.valid   = 1'b1;
                st_d.ap      = ap_req_i;
                st_d.order   = burst_order_e'(order_bit_i);
                st_d.len_log = dec_log_i;
                st_d.last    = dec_last_i;
                st_d.pair    = '0;
                st_d.base    = start_col_i;
                st_d.cols    = lane_col_i;
                st_d.done    = (dec_last_i == '0);
            end
        end else if (more_q) begin
            if (term_i) begin
                st_d.valid = 1'b0;
                st_d.done  = 1'b1;
                st_d.ap    = 1'b0;
                st_d.cols  = '0;
            end else begin
                st_d.pair = calc_pair_o;
                st_d.cols = lane_col_i;
                st_d.done = (calc_pair_o == st_q.last);
            end
        end else begin
            st_d.valid = 1'b0;
            st_d.ap    = 1'b0;
            st_d.cols  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        valid_o    = st_q.valid;
        col_rise_o = st_q.cols[0];
        col_fall_o = st_q.cols[1];
        ap_o       = st_q.ap;
        done_o     = st_q.done;
        err_o      = st_q.err;
    end

    // R8
    reserved_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && dec_reserved_i) |=> (err_o && done_o && !valid_o));

    // R7
    term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (more_q && term_i && !start_i) |=> (done_o && !valid_o));

    // R6
    done_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && done_o && !start_i) |=> (!valid_o && !done_o));

    // R1
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({valid_o, err_o}));

    // R9
    start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !dec_reserved_i) |=> (valid_o && !err_o));

endmodule

// File: rtl/ddr_burst_colgen.sv
module ddr_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             ap_req_i,
    input  logic [3:0]       mode_i,
    input  logic             term_i,
    output logic             beat_valid_o,
    output logic [COL_W-1:0] col_rise_o,
    output logic [COL_W-1:0] col_fall_o,
    output logic             ap_o,
    output logic             done_o,
    output logic             err_o
);

    logic [LOG_W-1:0]            dec_log;
    logic [PAIR_W-1:0]           dec_last;
    logic                        dec_reserved;
    logic [COL_W-1:0]            calc_base;
    logic [PAIR_W-1:0]           calc_pair;
    logic [LOG_W-1:0]            calc_log;
    burst_order_e                calc_order;
    logic [LANES-1:0][COL_W-1:0] lane_col;

    colgen_mode_dec u_dec (
        .len_code_i  (mode_i[LEN_CODE_W-1:0]),
        .len_log_o   (dec_log),
        .last_pair_o (dec_last),
        .reserved_o  (dec_reserved)
    );

    colgen_order #(.COL_W(COL_W)) u_order (
        .base_i     (calc_base),
        .pair_i     (calc_pair),
        .len_log_i  (calc_log),
        .order_i    (calc_order),
        .lane_col_o (lane_col)
    );

    colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .start_col_i    (start_col_i),
        .ap_req_i       (ap_req_i),
        .order_bit_i    (mode_i[LEN_CODE_W]),
        .term_i         (term_i),
        .dec_log_i      (dec_log),
        .dec_last_i     (dec_last),
        .dec_reserved_i (dec_reserved),
        .lane_col_i     (lane_col),
        .calc_base_o    (calc_base),
        .calc_pair_o    (calc_pair),
        .calc_log_o     (calc_log),
        .calc_order_o   (calc_order),
        .valid_o        (beat_valid_o),
        .col_rise_o     (col_rise_o),
        .col_fall_o     (col_fall_o),
        .ap_o           (ap_o),
        .done_o         (done_o),
        .err_o          (err_o)
    );

    // R4
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && $past(beat_valid_o) && !$past(start_i))
            |-> $stable(col_rise_o[COL_W-1:MAX_LEN_LOG]));

    // R4
    lane_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o |-> (col_rise_o[COL_W-1:MAX_LEN_LOG] == col_fall_o[COL_W-1:MAX_LEN_LOG]));

endmodule

// File: tb/sim_ddr_burst_colgen.sv
`timescale 1ns/100ps
module sim_ddr_burst_colgen;

    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic             ap_req_i = 1'b0;
    logic [3:0]       mode_i = '0;
    logic             term_i = 1'b0;
    logic             beat_valid_o;
    logic [COL_W-1:0] col_rise_o;
    logic [COL_W-1:0] col_fall_o;
    logic             ap_o;
    logic             done_o;
    logic             err_o;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ddr_burst_colgen #(.COL_W(COL_W)) u0 (.*);

    function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] col, int k, int lg, bit ilv);
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] low;
        mask = COL_W'((1 << lg) - 1);
        low  = ilv ? (col ^ COL_W'(k)) : (col + COL_W'(k));
        return (col & ~mask) | (low & mask);
    endfunction

    function automatic int code_log(logic [2:0] code);
        case (code)
            3'b001: return 1;
            3'b010: return 2;
            3'b011: return 3;
            default: return 0;
        endcase
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_idle(string req);
        chk(beat_valid_o == 1'b0, req, 32'(beat_valid_o), 0);
        chk(done_o == 1'b0, req, 32'(done_o), 0);
    endtask

    // term_at: pair index that is not shown because term_i ends the burst (-1 none)
    // leave_at: return right after checking this pair, leaving it on the outputs (-1 none)
    task automatic burst(logic [2:0] code, bit ilv, logic [COL_W-1:0] col, bit ap,
                         int term_at, int leave_at);
        int lg;
        int npairs;
        lg = code_log(code);
        start_i     = 1'b1;
        start_col_i = col;
        ap_req_i    = ap;
        mode_i      = {ilv, code};
        step();
        start_i = 1'b0;
        if (lg == 0) begin
            // R8
            chk(err_o == 1'b1, "R8 err", 32'(err_o), 1);
            chk(done_o == 1'b1, "R8 done", 32'(done_o), 1);
            chk(beat_valid_o == 1'b0, "R8 valid", 32'(beat_valid_o), 0);
            if (leave_at >= 0) return;
            step();
            chk(err_o == 1'b0, "R8 err pulse", 32'(err_o), 0);
            chk_idle("R8 idle");
            return;
        end
        npairs = (1 << lg) / 2;
        for (int p = 0; p < npairs; p++) begin
            if (p == term_at) begin
                // R7
                chk(beat_valid_o == 1'b0, "R7 stop valid", 32'(beat_valid_o), 0);
                chk(done_o == 1'b1, "R7 stop done", 32'(done_o), 1);
                step();
                chk_idle("R7 after stop");
                return;
            end
            // R1 R5 R6
            chk(beat_valid_o == 1'b1, "R1 valid", 32'(beat_valid_o), 1);
            chk(ap_o == ap, "R5 ap", 32'(ap_o), 32'(ap));
            chk(done_o == (p == npairs - 1), "R6 done", 32'(done_o), 32'(p == npairs - 1));
            // R2 R3 R4
            chk(col_rise_o == exp_col(col, 2 * p, lg, ilv), ilv ? "R3 rise" : "R2 rise",
                32'(col_rise_o), 32'(exp_col(col, 2 * p, lg, ilv)));
            chk(col_fall_o == exp_col(col, 2 * p + 1, lg, ilv), ilv ? "R3 fall" : "R2 fall",
                32'(col_fall_o), 32'(exp_col(col, 2 * p + 1, lg, ilv)));
            if (p == leave_at) return;
            if (p + 1 == term_at) term_i = 1'b1;
            step();
            term_i = 1'b0;
        end
        // R6 pulse over
        chk_idle("R6 end");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        step();
        step();
        // R10
        chk(beat_valid_o == 0 && done_o == 0 && err_o == 0 && ap_o == 0, "R10 flags",
            32'({beat_valid_o, done_o, err_o, ap_o}), 0);
        chk(col_rise_o == 0 && col_fall_o == 0, "R10 cols", 32'(col_rise_o | col_fall_o), 0);
        rst_n = 1'b1;
        step();

        // Directed orderings from the requirements
        burst(3'b010, 1'b0, 10'h101, 1'b0, -1, -1);  // R2 linear 4 from 1: 1,2,3,0
        burst(3'b011, 1'b0, 10'h2a5, 1'b1, -1, -1);  // R2 linear 8 from 5
        burst(3'b011, 1'b1, 10'h3fd, 1'b0, -1, -1);  // R3 xor 8 from 5: 5,4,7,6,1,0,3,2
        burst(3'b010, 1'b1, 10'h01a, 1'b1, -1, -1);  // R3 xor 4 from 2: 2,3,0,1
        burst(3'b001, 1'b0, 10'h3ff, 1'b1, -1, -1);  // R1 length 2 wrap at top
        burst(3'b000, 1'b0, 10'h055, 1'b1, -1, -1);  // R8 reserved
        burst(3'b111, 1'b1, 10'h155, 1'b0, -1, -1);  // R8 reserved

        // R7 term while idle has no effect
        term_i = 1'b1;
        step();
        term_i = 1'b0;
        chk_idle("R7 idle term");
        // R7 term on final pair has no effect on outputs
        burst(3'b010, 1'b0, 10'h010, 1'b0, -1, 1);
        term_i = 1'b1;
        step();
        term_i = 1'b0;
        chk_idle("R7 final term");
        burst(3'b011, 1'b1, 10'h0c3, 1'b1, 2, -1);   // R7 stop after two pairs

        // R9 back-to-back and mid-burst restart
        burst(3'b010, 1'b0, 10'h123, 1'b1, -1, 1);
        burst(3'b011, 1'b1, 10'h2f6, 1'b0, -1, 3);
        burst(3'b000, 1'b0, 10'h000, 1'b0, -1, -1);  // R9 reserved right after final pair
        burst(3'b011, 1'b0, 10'h0ff, 1'b0, -1, 0);
        term_i = 1'b1;                                // R9 start wins over term
        burst(3'b001, 1'b1, 10'h200, 1'b1, -1, -1);
        term_i = 1'b0;

        // Random bursts
        for (int i = 0; i < 400; i++) begin
            logic [2:0] code;
            int lg;
            int np;
            int t_at;
            int l_at;
            code = ($urandom % 8 < 6) ? 3'(1 + $urandom % 3) : 3'($urandom);
            lg   = code_log(code);
            np   = (lg == 0) ? 1 : (1 << lg) / 2;
            t_at = -1;
            l_at = -1;
            if (np > 1 && ($urandom % 4 == 0)) t_at = 1 + int'($urandom % (np - 1));
            if (t_at < 0 && ($urandom % 3 == 0)) l_at = np - 1;
            if (t_at < 0 && l_at < 0 && np > 1 && ($urandom % 8 == 0))
                l_at = int'($urandom % (np - 1));
            if (lg == 0 && l_at >= 0) l_at = 0;
            burst(code, 1'($urandom), 10'($urandom), 1'($urandom), t_at, l_at);
        end
        step();
        step();
        chk_idle("R6 final idle");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule